// File: doc/BRIEF.md
# Multiply and divide unit

A multi-cycle integer arithmetic unit that multiplies or divides, signed or unsigned, at a selectable operand width of one quarter, one half or all of the `XLEN`-bit datapath (8, 16 or 32 bits with the default). A multiply returns a double-width product split into an upper and a lower result word. A divide takes a double-width dividend made of the upper word on top of the lower word. It returns the quotient in the lower result word and the remainder in the upper one. A third operation multiplies signed and keeps only the lower half of the product. It reports whether that half lost information.

The core unit drives a request with `start_i` while the unit is idle. The operation, signedness, width and the three operand words are captured on that edge. Multiplication uses shift-and-add and division uses restoring division, one bit per cycle. The result, the carry/overflow flag and the divide-fault flag appear together with a single-cycle `done_o`. They hold until the next completion.

Top module: `mdu_unit`

## Requirements
- R1: After reset, `hi_o`, `lo_o`, `ovf_o`, `fault_o`, `done_o` and `busy_o` are all 0.
- R2: Operation code 0 (multiply) with `signed_i`=0 places the lower W bits of the product of `lo_i` and `src_i` on `lo_o` and the upper W bits on `hi_o`. For W=8 the two words together form the 16-bit product.
- R3: An unsigned multiply sets `ovf_o` exactly when the upper half of the product is nonzero.
- R4: A signed multiply (code 0, `signed_i`=1) yields the two's-complement product split as in R2. It clears `ovf_o` only when the 2W-bit product equals the sign extension of its lower W bits, and sets it otherwise.
- R5: Operation code 2 multiplies `lo_i` by `src_i` as signed values whatever `signed_i` is. It writes only the lower W bits to `lo_o` and leaves `hi_o` unchanged. It sets `ovf_o` when the product lies outside the signed W-bit range.
- R6: Operation code 1 (divide) with `signed_i`=0 divides the 2W-bit dividend {`hi_i`[W-1:0], `lo_i`[W-1:0]} by `src_i`[W-1:0]. It returns the quotient on `lo_o` and the remainder on `hi_o`, and `ovf_o` reads 0.
- R7: A signed divide rounds the quotient toward zero, and the remainder takes the sign of the dividend.
- R8: A divisor of zero raises `fault_o`, and neither `hi_o` nor `lo_o` changes.
- R9: `fault_o` is also raised, with results unchanged, when an unsigned quotient exceeds W bits or a signed quotient is outside the signed W-bit range. A quotient exactly at the signed minimum is not a fault. Any multiply clears `fault_o`.
- R10: `done_o` is high for exactly one cycle. It first reads high after the (N+2)-th rising edge, counting the edge that samples `start_i`, where N is W for a multiply and 2W for a divide.
- R11: `start_i` while `busy_o` is high is ignored: the running operation completes with its own result and timing.
- R12: Operand bits above W are ignored, and result bits above W of a written word are 0.
- R13: `size_i` encodes 0 as W=XLEN/4, 1 as W=XLEN/2, and 2 or 3 as W=XLEN. Operation code 3 acts as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when idle |
| op_i | input | 2 | 0 multiply, 1 divide, 2 truncated signed multiply, 3 multiply |
| signed_i | input | 1 | Signed operands for codes 0, 1 and 3 |
| size_i | input | 2 | Operand width select |
| hi_i | input | XLEN | Upper dividend word |
| lo_i | input | XLEN | Multiplicand or lower dividend word |
| src_i | input | XLEN | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| hi_o | output | XLEN | Upper product half or remainder |
| lo_o | output | XLEN | Lower product half or quotient |
| ovf_o | output | 1 | Carry/overflow flag of the last multiply |
| fault_o | output | 1 | Divide fault of the last divide |

## Verification
The bench builds the unit with the default `XLEN` of 32, so all three operand widths of 8, 16 and 32 bits exist in the same instance. At that size the 8-bit corners can be reached cheaply. These are the signed minimum quotient, the quotient one past it, and products that just cross the signed range. The full 64-bit product and the 66-cycle divide latency are still exercised. Width code 3 and operation code 3 are also reachable there, alongside the wide-word cases.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_DIV  = 2'b01,
    OP_TMUL = 2'b10,
    OP_MULX = 2'b11
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } mdu_st_e;

  localparam int unsigned EXT_W = 128;

  // extend from bit nb-1 upward, sign or zero
  function automatic logic [EXT_W-1:0] ext_bits(input logic [EXT_W-1:0] v,
                                                input logic [6:0] nb,
                                                input logic s);
    logic [EXT_W-1:0] r;
    logic             top;
    top = s & v[nb - 7'd1];
    for (int i = 0; i < EXT_W; i++) r[i] = (7'(i) < nb) ? v[i] : top;
    return r;
  endfunction

endpackage

// File: rtl/mdu_prep.sv
module mdu_prep #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op_i,
  input  logic            sgn_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] src_i,
  output logic [6:0]      wb_o,
  output logic            eff_sgn_o,
  output logic [2*XLEN-1:0] mc_mag_o,
  output logic [2*XLEN-1:0] mp_mag_o,
  output logic [2*XLEN-1:0] num_o,
  output logic [XLEN-1:0] den_o,
  output logic            neg_prod_o,
  output logic            neg_quo_o,
  output logic            neg_rem_o,
  output logic            den_zero_o,
  output logic [7:0]      steps_o
);
  import mdu_pkg::*;

  localparam int DW = 2 * XLEN;

  logic [6:0]      wb, wb2;
  logic [XLEN-1:0] mask;
  logic            s, neg_a, neg_b, neg_n;
  logic [DW-1:0]   a_x, b_x, dd, n_x, n_mag;

  always_comb begin
    unique case (size_i)
      2'b00:   wb = 7'(XLEN / 4);
      2'b01:   wb = 7'(XLEN / 2);
      default: wb = 7'(XLEN);
    endcase
    wb2   = wb << 1;
    mask  = XLEN'((DW'(1) << wb) - DW'(1));
    s     = sgn_i | (op_i == OP_TMUL);
    a_x   = DW'(ext_bits(EXT_W'(lo_i & mask), wb, s));
    b_x   = DW'(ext_bits(EXT_W'(src_i & mask), wb, s));
    neg_a = s & a_x[DW-1];
    neg_b = s & b_x[DW-1];
    dd    = (DW'(hi_i & mask) << wb) | DW'(lo_i & mask);
    n_x   = DW'(ext_bits(EXT_W'(dd), wb2, s));
    neg_n = s & n_x[DW-1];
    n_mag = neg_n ? -n_x : n_x;
  end

  assign wb_o       = wb;
  assign eff_sgn_o  = s;
  assign mc_mag_o   = neg_a ? -a_x : a_x;
  assign mp_mag_o   = neg_b ? -b_x : b_x;
  assign den_o      = mp_mag_o[XLEN-1:0];
  assign num_o      = n_mag << (8'(DW) - 8'(wb2));
  assign neg_prod_o = neg_a ^ neg_b;
  assign neg_quo_o  = neg_n ^ neg_b;
  assign neg_rem_o  = neg_n;
  assign den_zero_o = (src_i & mask) == '0;
  assign steps_o    = (op_i == OP_DIV) ? 8'(wb2) : 8'(wb);

endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] mcand_i,
  input  logic [DW-1:0] mplier_i,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] mcand_q, mplier_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
      acc_q    <= '0;
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [2*XLEN-1:0] num_i,
  input  logic [XLEN-1:0]   den_i,
  output logic [2*XLEN-1:0] quo_o,
  output logic [XLEN-1:0]   rem_o
);
  localparam int DW = 2 * XLEN;

  logic [DW-1:0]   num_q, quo_q;
  logic [XLEN-1:0] rem_q, den_q;
  logic [XLEN:0]   trial;
  logic            ge;

  assign trial = {rem_q, num_q[DW-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load_i) begin
      num_q <= num_i;
      den_q <= den_i;
      quo_q <= '0;
      rem_q <= '0;
    end else if (step_i) begin
      rem_q <= ge ? (trial[XLEN-1:0] - den_q) : trial[XLEN-1:0];
      quo_q <= {quo_q[DW-2:0], ge};
      num_q <= num_q << 1;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  p_rem_below_den_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && den_q != '0) |=> (rem_q < den_q));

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            signed_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] src_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o,
  output logic            ovf_o,
  output logic            fault_o
);
  import mdu_pkg::*;

  localparam int DW = 2 * XLEN;

  mdu_st_e         st_q;
  mdu_op_e         op_q;
  logic [7:0]      cnt_q;
  logic [6:0]      wb_q;
  logic            sgn_q, negp_q, negq_q, negr_q, dz_q;
  logic [XLEN-1:0] hi_q, lo_q;
  logic            ovf_q, fault_q, done_q;

  logic [6:0]      p_wb;
  logic            p_sgn, p_negp, p_negq, p_negr, p_dz;
  logic [DW-1:0]   p_mc, p_mp, p_num;
  logic [XLEN-1:0] p_den;
  logic [7:0]      p_steps;

  logic            start_ok, run;
  logic [DW-1:0]   acc, quo_raw;
  logic [XLEN-1:0] rem_raw;

  mdu_prep #(.XLEN(XLEN)) u_prep (
    .op_i(op_i), .sgn_i(signed_i), .size_i(size_i),
    .hi_i(hi_i), .lo_i(lo_i), .src_i(src_i),
    .wb_o(p_wb), .eff_sgn_o(p_sgn), .mc_mag_o(p_mc), .mp_mag_o(p_mp),
    .num_o(p_num), .den_o(p_den), .neg_prod_o(p_negp), .neg_quo_o(p_negq),
    .neg_rem_o(p_negr), .den_zero_o(p_dz), .steps_o(p_steps)
  );

  assign start_ok = start_i && (st_q == ST_IDLE);
  assign run      = (st_q == ST_RUN);

  mdu_mul_core #(.DW(DW)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_ok),
    .step_i(run && op_q != OP_DIV),
    .mcand_i(p_mc), .mplier_i(p_mp), .acc_o(acc)
  );

  mdu_div_core #(.XLEN(XLEN)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_ok),
    .step_i(run && op_q == OP_DIV),
    .num_i(p_num), .den_i(p_den), .quo_o(quo_raw), .rem_o(rem_raw)
  );

  // result shaping
  logic [XLEN-1:0] mask_f, p_lo, p_hi, rem_s;
  logic [DW-1:0]   prod, p_sx, quo_s, q_sx;
  logic            mul_ovf, q_bad, d_fault;

  always_comb begin
    mask_f  = XLEN'((DW'(1) << wb_q) - DW'(1));
    prod    = negp_q ? -acc : acc;
    p_lo    = prod[XLEN-1:0] & mask_f;
    p_hi    = XLEN'(prod >> wb_q) & mask_f;
    p_sx    = DW'(ext_bits(EXT_W'(prod), wb_q, 1'b1));
    mul_ovf = sgn_q ? (prod != p_sx) : (p_hi != '0);
    quo_s   = negq_q ? -quo_raw : quo_raw;
    rem_s   = negr_q ? -rem_raw : rem_raw;
    q_sx    = DW'(ext_bits(EXT_W'(quo_s), wb_q, 1'b1));
    q_bad   = sgn_q ? (quo_s != q_sx) : ((quo_raw >> wb_q) != '0);
    d_fault = dz_q | q_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_MUL;
      cnt_q   <= '0;
      wb_q    <= 7'd8;
      sgn_q   <= 1'b0;
      negp_q  <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      dz_q    <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      ovf_q   <= 1'b0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FIN);
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q   <= ST_RUN;
          op_q   <= (op_i == OP_MULX) ? OP_MUL : mdu_op_e'(op_i);
          cnt_q  <= p_steps;
          wb_q   <= p_wb;
          sgn_q  <= p_sgn;
          negp_q <= p_negp;
          negq_q <= p_negq;
          negr_q <= p_negr;
          dz_q   <= p_dz;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 8'd1;
          if (cnt_q == 8'd1) st_q <= ST_FIN;
        end
        ST_FIN: begin
          st_q <= ST_IDLE;
          unique case (op_q)
            OP_DIV: begin
              fault_q <= d_fault;
              ovf_q   <= 1'b0;
              if (!d_fault) begin
                lo_q <= quo_s[XLEN-1:0] & mask_f;
                hi_q <= rem_s & mask_f;
              end
            end
            OP_TMUL: begin
              lo_q    <= p_lo;
              ovf_q   <= mul_ovf;
              fault_q <= 1'b0;
            end
            default: begin
              lo_q    <= p_lo;
              hi_q    <= p_hi;
              ovf_q   <= mul_ovf;
              fault_q <= 1'b0;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign ovf_o   = ovf_q;
  assign fault_o = fault_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_fin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st_q == ST_FIN));

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(op_q) && $stable(wb_q));

  p_fault_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (hi_o == $past(hi_o)) && (lo_o == $past(lo_o)));

  p_ovf_unsigned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_MUL && !sgn_q) |-> (ovf_o == (hi_o != '0)));

  p_upper_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && op_q != OP_TMUL) |-> (((hi_o | lo_o) & ~mask_f) == '0));

endmodule

// File: tb/mdu_unit_test.sv
module mdu_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        signed_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] hi_i = '0, lo_i = '0, src_i = '0;
  logic        busy_o, done_o, ovf_o, fault_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mdu_unit #(.XLEN(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i),
    .signed_i(signed_i), .size_i(size_i), .hi_i(hi_i), .lo_i(lo_i),
    .src_i(src_i), .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o),
    .lo_o(lo_o), .ovf_o(ovf_o), .fault_o(fault_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        sg;
    logic [1:0]  sz;
    logic [31:0] h, l, s, eh, el;
    logic        ecf;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'd0, 1'b0, 2'd0, 32'h0, 32'h0F, 32'h11, 32'h0, 32'hFF, 1'b0},
    '{2'd0, 1'b0, 2'd0, 32'h0, 32'hFF, 32'hFF, 32'hFE, 32'h01, 1'b1},
    '{2'd0, 1'b1, 2'd0, 32'h0, 32'hFF, 32'h05, 32'hFF, 32'hFB, 1'b0},
    '{2'd0, 1'b1, 2'd0, 32'h0, 32'h80, 32'h80, 32'h40, 32'h00, 1'b1},
    '{2'd0, 1'b0, 2'd1, 32'h0, 32'h1234, 32'h0100, 32'h0012, 32'h3400, 1'b1},
    '{2'd0, 1'b1, 2'd2, 32'h0, 32'hFFFFFFFE, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFA, 1'b0},
    '{2'd0, 1'b0, 2'd2, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h1, 1'b1},
    '{2'd0, 1'b1, 2'd1, 32'h0, 32'h7FFF, 32'h7FFF, 32'h3FFF, 32'h0001, 1'b1},
    '{2'd1, 1'b0, 2'd0, 32'h00, 32'h64, 32'h07, 32'h02, 32'h0E, 1'b0},
    '{2'd1, 1'b0, 2'd1, 32'h0001, 32'h0000, 32'h0003, 32'h0001, 32'h5555, 1'b0},
    '{2'd1, 1'b1, 2'd0, 32'hFF, 32'h9C, 32'h07, 32'hFE, 32'hF2, 1'b0},
    '{2'd1, 1'b1, 2'd1, 32'h0, 32'h0064, 32'hFFF9, 32'h0002, 32'hFFF2, 1'b0},
    '{2'd1, 1'b1, 2'd2, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hE, 1'b0},
    '{2'd1, 1'b0, 2'd2, 32'h1, 32'h0, 32'h10, 32'h0, 32'h10000000, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic sg, input logic [1:0] sz,
                        input logic [31:0] h, input logic [31:0] l,
                        input logic [31:0] s, output int edges);
    @(negedge clk);
    op_i = op; signed_i = sg; size_i = sz; hi_i = h; lo_i = l; src_i = s;
    start_i = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && edges < 500) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op, input logic sg);
    if (op == 2'd1) return sg ? "R7" : "R6";
    return sg ? "R4" : "R2 R3";
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: no completion, got %h expected %h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(hi_o == 0 && lo_o == 0, "R1", "results in reset", {hi_o[15:0], lo_o[15:0]}, 32'h0);
    chk({done_o, busy_o, ovf_o, fault_o} == 4'b0, "R1", "flags in reset",
        32'({done_o, busy_o, ovf_o, fault_o}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hi_o == 0 && lo_o == 0 && !done_o && !busy_o, "R1", "after release",
        {hi_o[15:0], lo_o[15:0]}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VT[i].op, VT[i].sg, VT[i].sz, VT[i].h, VT[i].l, VT[i].s, e);
      chk(hi_o == VT[i].eh, tag_of(VT[i].op, VT[i].sg), $sformatf("vec %0d hi", i), hi_o, VT[i].eh);
      chk(lo_o == VT[i].el, tag_of(VT[i].op, VT[i].sg), $sformatf("vec %0d lo", i), lo_o, VT[i].el);
      chk(ovf_o == VT[i].ecf, tag_of(VT[i].op, VT[i].sg), $sformatf("vec %0d ovf", i),
          32'(ovf_o), 32'(VT[i].ecf));
      chk(!fault_o, tag_of(VT[i].op, VT[i].sg), $sformatf("vec %0d fault", i), 32'(fault_o), 32'h0);
    end

    // R10 latency and pulse width
    run_op(2'd0, 1'b0, 2'd0, 32'h0, 32'h0F, 32'h11, e);
    chk(e == 10, "R10", "8-bit multiply edges", 32'(e), 32'd10);
    @(negedge clk);
    chk(!done_o, "R10", "done one cycle", 32'(done_o), 32'h0);
    run_op(2'd1, 1'b0, 2'd0, 32'h0, 32'h64, 32'h07, e);
    chk(e == 18, "R10", "8-bit divide edges", 32'(e), 32'd18);

    // R8 zero divisor keeps results
    run_op(2'd0, 1'b0, 2'd0, 32'h0, 32'h0F, 32'h11, e);
    run_op(2'd1, 1'b0, 2'd0, 32'h0, 32'h05, 32'h0, e);
    chk(fault_o, "R8", "zero divisor fault", 32'(fault_o), 32'h1);
    chk(hi_o == 32'h0 && lo_o == 32'hFF, "R8", "results kept", lo_o, 32'hFF);

    // R9 quotient overflow
    run_op(2'd1, 1'b0, 2'd0, 32'h02, 32'h00, 32'h02, e);
    chk(fault_o, "R9", "unsigned quotient 256", 32'(fault_o), 32'h1);
    chk(lo_o == 32'hFF && hi_o == 32'h0, "R9", "unsigned fault keeps", lo_o, 32'hFF);
    run_op(2'd1, 1'b1, 2'd0, 32'hFF, 32'h80, 32'hFF, e);
    chk(fault_o, "R9", "signed -128 / -1", 32'(fault_o), 32'h1);
    run_op(2'd1, 1'b1, 2'd0, 32'hFF, 32'h80, 32'h01, e);
    chk(!fault_o, "R9", "signed -128 / 1 fits", 32'(fault_o), 32'h0);
    chk(lo_o == 32'h80 && hi_o == 32'h0, "R9", "signed minimum quotient", lo_o, 32'h80);
    run_op(2'd0, 1'b0, 2'd0, 32'h0, 32'hFF, 32'hFF, e);
    chk(!fault_o, "R9", "multiply clears fault", 32'(fault_o), 32'h0);

    // R5 truncated multiply: hi is FE from the step above
    run_op(2'd2, 1'b0, 2'd1, 32'h1234, 32'h0100, 32'h0080, e);
    chk(lo_o == 32'h8000, "R5", "truncated lo", lo_o, 32'h8000);
    chk(hi_o == 32'hFE, "R5", "hi untouched", hi_o, 32'hFE);
    chk(ovf_o, "R5", "out of signed range", 32'(ovf_o), 32'h1);
    run_op(2'd2, 1'b0, 2'd1, 32'h0, 32'hFFFF, 32'h0002, e);
    chk(lo_o == 32'hFFFE && hi_o == 32'hFE, "R5", "signed -1*2", lo_o, 32'hFFFE);
    chk(!ovf_o, "R5", "in signed range", 32'(ovf_o), 32'h0);

    // R12 upper operand bits ignored
    run_op(2'd0, 1'b0, 2'd0, 32'hDEADBEEF, 32'hABCDEF03, 32'h12345604, e);
    chk(lo_o == 32'h0C && hi_o == 32'h0, "R12", "masked operands", lo_o, 32'h0C);

    // R13 encodings
    run_op(2'd3, 1'b0, 2'd0, 32'h0, 32'h02, 32'h03, e);
    chk(lo_o == 32'h06 && hi_o == 32'h0, "R13", "op code 3", lo_o, 32'h06);
    run_op(2'd0, 1'b0, 2'd3, 32'h0, 32'h00010000, 32'h00010000, e);
    chk(hi_o == 32'h1 && lo_o == 32'h0 && ovf_o, "R13", "size code 3", hi_o, 32'h1);
    chk(e == 34, "R13", "size code 3 latency", 32'(e), 32'd34);

    // R11 start during busy is ignored
    @(negedge clk);
    op_i = 2'd1; signed_i = 1'b0; size_i = 2'd2; hi_i = 32'h1; lo_i = 32'h0; src_i = 32'h10;
    start_i = 1'b1;
    @(posedge clk);
    e = 1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) begin @(posedge clk); e++; @(negedge clk); end
    op_i = 2'd0; size_i = 2'd0; lo_i = 32'h3; src_i = 32'h3; start_i = 1'b1;
    @(posedge clk); e++; @(negedge clk);
    start_i = 1'b0;
    while (!done_o && e < 500) begin @(posedge clk); e++; @(negedge clk); end
    chk(lo_o == 32'h10000000 && hi_o == 32'h0, "R11", "divide result kept", lo_o, 32'h10000000);
    chk(e == 66, "R11", "32-bit divide edges", 32'(e), 32'd66);
    @(negedge clk);
    chk(!busy_o && !done_o, "R11", "no second operation", 32'({busy_o, done_o}), 32'h0);

    finish_run();
  end

endmodule